// File: doc/BRIEF.md
# Host-to-Slave Management Mailbox

This block is a small register file shared between a host bus and a local management processor (the slave). Through it the host hands over a command: it checks that the mailbox is idle, writes a command code, writes one byte of payload and then raises the busy flag. The slave is told about each of these steps through its own interrupt-status register. It reads the code and the payload, posts a status code and drops the busy flag. Dropping the flag raises a host interrupt.

Each side has a one-cycle write strobe and a read strobe with an address. Read data is combinational from the stored state. Writes and read side effects take effect at the rising clock edge that samples the strobe. The shared code location has two views. The slave sees the host's last command code, and the host sees the slave's last status code. A ready flag and an error flag are written only by the slave. When a transfer fails, the slave posts the ready code as the status and leaves the error flag set for the host to read.

Top module: `mgmt_mailbox`

## Requirements
- R1: After reset every register reads 0, and both `slvIrq` and `hostIrq` are low.
- R2: While the busy flag (flag bit 0) is 1, host writes to the code location (host address 1) and to the data location (host address 2) change no state and raise no event.
- R3: A host write to the flag location (host address 0) with bit 0 = 1 sets the busy flag. Every 0-to-1 change of the busy flag sets interrupt-status bit 0 (slave address 3).
- R4: An accepted host write to the code location stores the command code, which the slave reads at slave address 1, and sets interrupt-status bit 1. An accepted host write to the data location stores the byte, which the slave reads at slave address 2, and sets interrupt-status bit 2.
- R5: A host read of host address 1 returns the status code last written by the slave to slave address 1, and sets interrupt-status bit 3.
- R6: A slave write to the flag location (slave address 0) loads the busy flag from bit 0. A 1-to-0 change of the busy flag sets `hostIrq`. `hostIrq` stays high until a host read of host address 0, and it stays high if a new 1-to-0 change happens in the same cycle as that read.
- R7: `slvIrq` is the OR of the interrupt-status bits ANDed with the enable register at slave address 4 (bits 3..0).
- R8: A slave write to slave address 3 clears each status bit written as 1. A bit whose event occurs in the same cycle stays set.
- R9: The ready flag (bit 1) and the error flag (bit 2) are loaded only by slave writes to the flag location, and they hold their value across host reads and host writes. The flag location reads {pending host interrupt at bit 3, error, ready, busy} on both sides.
- R10: When the host sets the busy flag in the same cycle that the slave writes the flag location, the slave's value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWe | input | 1 | Host write strobe |
| hostRe | input | 1 | Host read strobe |
| hostAddr | input | 2 | Host address: 0 flags, 1 code, 2 data |
| hostWdata | input | DATA_W | Host write data |
| hostRdata | output | DATA_W | Host read data |
| slvWe | input | 1 | Slave write strobe |
| slvAddr | input | 3 | Slave address: 0 flags, 1 code, 2 data, 3 int status, 4 enable |
| slvWdata | input | DATA_W | Slave write data |
| slvRdata | output | DATA_W | Slave read data |
| slvIrq | output | 1 | Slave interrupt |
| hostIrq | output | 1 | Host interrupt |

## Verification
Every stored result, whether a code, data, flag, status bit or `hostIrq`, changes at the rising edge that samples the strobe. The read data and `slvIrq` show that change combinationally from then on, so each result is due one edge after its stimulus. The bench drives inputs just after the falling edge and compares a behavioural model against all outputs at every falling edge. Its directed checks read each result back in the cycle after the access that should cause it. The checks cover the same-cycle collisions called out in R6, R8 and R10.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int HOST_AW = 2;
  localparam int SLV_AW  = 3;
  localparam int NUM_EV  = 4;

  localparam logic [HOST_AW-1:0] H_FLAG = 2'd0;
  localparam logic [HOST_AW-1:0] H_CODE = 2'd1;
  localparam logic [HOST_AW-1:0] H_DATA = 2'd2;

  localparam logic [SLV_AW-1:0] S_FLAG = 3'd0;
  localparam logic [SLV_AW-1:0] S_CODE = 3'd1;
  localparam logic [SLV_AW-1:0] S_DATA = 3'd2;
  localparam logic [SLV_AW-1:0] S_IRQ  = 3'd3;
  localparam logic [SLV_AW-1:0] S_EN   = 3'd4;

  // interrupt-status bit positions
  localparam int EV_BUSY = 0;
  localparam int EV_CODE = 1;
  localparam int EV_DATA = 2;
  localparam int EV_STAT = 3;

  typedef struct packed {
    logic ldCtrl;    // host command code accepted
    logic ldStatus;  // slave status code written
    logic ldData;    // host payload accepted
  } dpStrobe_t;
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWe,
  input  logic               hostRe,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic               hostSetBit,
  input  logic               slvWe,
  input  logic [SLV_AW-1:0]  slvAddr,
  input  logic [NUM_EV-1:0]  slvLow,
  output dpStrobe_t          strobe,
  output logic               busy,
  output logic               txReady,
  output logic               errHeld,
  output logic               hostPend,
  output logic [NUM_EV-1:0]  irqFlags,
  output logic [NUM_EV-1:0]  irqEn,
  output logic               slvIrq
);
  logic hostFlagWr, hostCodeWr, hostDataWr, hostCodeRd, hostFlagRd;
  logic slvFlagWr, slvCodeWr, slvIrqWr, slvEnWr;
  logic busyNext, busyRise, busyFall;
  logic [NUM_EV-1:0] events, clearMask;

  always_comb begin
    hostFlagWr = hostWe && (hostAddr == H_FLAG);
    hostCodeWr = hostWe && (hostAddr == H_CODE) && !busy;
    hostDataWr = hostWe && (hostAddr == H_DATA) && !busy;
    hostCodeRd = hostRe && (hostAddr == H_CODE);
    hostFlagRd = hostRe && (hostAddr == H_FLAG);
    slvFlagWr  = slvWe && (slvAddr == S_FLAG);
    slvCodeWr  = slvWe && (slvAddr == S_CODE);
    slvIrqWr   = slvWe && (slvAddr == S_IRQ);
    slvEnWr    = slvWe && (slvAddr == S_EN);
  end

  // slave write of the flag location takes priority over a host set
  always_comb begin
    if (slvFlagWr)                     busyNext = slvLow[0];
    else if (hostFlagWr && hostSetBit) busyNext = 1'b1;
    else                               busyNext = busy;
  end

  assign busyRise = !busy && busyNext;
  assign busyFall = busy && !busyNext;

  always_comb begin
    events          = '0;
    events[EV_BUSY] = busyRise;
    events[EV_CODE] = hostCodeWr;
    events[EV_DATA] = hostDataWr;
    events[EV_STAT] = hostCodeRd;
    clearMask       = slvIrqWr ? slvLow : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      txReady  <= 1'b0;
      errHeld  <= 1'b0;
      hostPend <= 1'b0;
      irqEn    <= '0;
    end else begin
      busy     <= busyNext;
      hostPend <= busyFall || (hostPend && !hostFlagRd);
      if (slvFlagWr) begin
        txReady <= slvLow[1];
        errHeld <= slvLow[2];
      end
      if (slvEnWr) irqEn <= slvLow;
    end
  end

  // per-event sticky flags: a new event outranks a clear in the same cycle
  for (genvar i = 0; i < NUM_EV; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) irqFlags[i] <= 1'b0;
      else       irqFlags[i] <= events[i] || (irqFlags[i] && !clearMask[i]);
    end
  end

  assign slvIrq = |(irqFlags & irqEn);

  always_comb begin
    strobe.ldCtrl   = hostCodeWr;
    strobe.ldStatus = slvCodeWr;
    strobe.ldData   = hostDataWr;
  end
endmodule

// File: rtl/mbox_dp.sv
module mbox_dp
  import mbox_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  input  logic [DATA_W-1:0]  hostWdata,
  input  logic [DATA_W-1:0]  slvWdata,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [SLV_AW-1:0]  slvAddr,
  input  logic [DATA_W-1:0]  flagView,
  input  logic [NUM_EV-1:0]  irqFlags,
  input  logic [NUM_EV-1:0]  irqEn,
  output logic [DATA_W-1:0]  hostRdata,
  output logic [DATA_W-1:0]  slvRdata
);
  localparam int PAD_W = DATA_W - NUM_EV;

  logic [DATA_W-1:0] ctrlCode, statusCode, payload;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlCode   <= '0;
      statusCode <= '0;
      payload    <= '0;
    end else begin
      if (strobe.ldCtrl)   ctrlCode   <= hostWdata;
      if (strobe.ldStatus) statusCode <= slvWdata;
      if (strobe.ldData)   payload    <= hostWdata;
    end
  end

  always_comb begin
    case (hostAddr)
      H_FLAG:  hostRdata = flagView;
      H_CODE:  hostRdata = statusCode;
      H_DATA:  hostRdata = payload;
      default: hostRdata = '0;
    endcase
  end

  always_comb begin
    case (slvAddr)
      S_FLAG:  slvRdata = flagView;
      S_CODE:  slvRdata = ctrlCode;
      S_DATA:  slvRdata = payload;
      S_IRQ:   slvRdata = {{PAD_W{1'b0}}, irqFlags};
      S_EN:    slvRdata = {{PAD_W{1'b0}}, irqEn};
      default: slvRdata = '0;
    endcase
  end
endmodule

// File: rtl/mgmt_mailbox.sv
module mgmt_mailbox
  import mbox_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWe,
  input  logic               hostRe,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [DATA_W-1:0]  hostWdata,
  output logic [DATA_W-1:0]  hostRdata,
  input  logic               slvWe,
  input  logic [SLV_AW-1:0]  slvAddr,
  input  logic [DATA_W-1:0]  slvWdata,
  output logic [DATA_W-1:0]  slvRdata,
  output logic               slvIrq,
  output logic               hostIrq
);
  localparam int PAD_W = DATA_W - NUM_EV;

  dpStrobe_t         strobe;
  logic              busy, txReady, errHeld, hostPend;
  logic [NUM_EV-1:0] irqFlags, irqEn;
  logic [DATA_W-1:0] flagView;

  mbox_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .hostWe    (hostWe),
    .hostRe    (hostRe),
    .hostAddr  (hostAddr),
    .hostSetBit(hostWdata[0]),
    .slvWe     (slvWe),
    .slvAddr   (slvAddr),
    .slvLow    (slvWdata[NUM_EV-1:0]),
    .strobe    (strobe),
    .busy      (busy),
    .txReady   (txReady),
    .errHeld   (errHeld),
    .hostPend  (hostPend),
    .irqFlags  (irqFlags),
    .irqEn     (irqEn),
    .slvIrq    (slvIrq)
  );

  assign flagView = {{PAD_W{1'b0}}, hostPend, errHeld, txReady, busy};
  assign hostIrq  = hostPend;

  mbox_dp #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .hostWdata(hostWdata),
    .slvWdata (slvWdata),
    .hostAddr (hostAddr),
    .slvAddr  (slvAddr),
    .flagView (flagView),
    .irqFlags (irqFlags),
    .irqEn    (irqEn),
    .hostRdata(hostRdata),
    .slvRdata (slvRdata)
  );
endmodule

// File: rtl/mbox_chk.sv
module mbox_chk
  import mbox_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               hostWe,
  input logic               hostRe,
  input logic [HOST_AW-1:0] hostAddr,
  input logic               slvWe,
  input logic [SLV_AW-1:0]  slvAddr,
  input logic               busy,
  input logic [NUM_EV-1:0]  irqFlags,
  input logic               hostIrq
);
  logic clrCode;
  assign clrCode = slvWe && (slvAddr == S_IRQ);

  // R3: busy rising edge leaves its status bit set
  a_r3_busy_rise_flag: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> irqFlags[EV_BUSY]);

  // R6: busy falling edge raises the host interrupt
  a_r6_fall_host_irq: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> hostIrq);

  // R6: host interrupt holds without a host flag read
  a_r6_host_irq_hold: assert property (@(posedge clk) disable iff (!rstN)
    (hostIrq && !(hostRe && hostAddr == H_FLAG)) |=> hostIrq);

  // R4: accepted command code write flags the slave
  a_r4_code_flag: assert property (@(posedge clk) disable iff (!rstN)
    (hostWe && hostAddr == H_CODE && !busy) |=> irqFlags[EV_CODE]);

  // R4: accepted payload write flags the slave
  a_r4_data_flag: assert property (@(posedge clk) disable iff (!rstN)
    (hostWe && hostAddr == H_DATA && !busy) |=> irqFlags[EV_DATA]);

  // R5: status read by the host flags the slave
  a_r5_stat_flag: assert property (@(posedge clk) disable iff (!rstN)
    (hostRe && hostAddr == H_CODE) |=> irqFlags[EV_STAT]);

  // R2: a blocked code write raises no event
  a_r2_blocked_code: assert property (@(posedge clk) disable iff (!rstN)
    (busy && hostWe && hostAddr == H_CODE && !irqFlags[EV_CODE] && !clrCode)
      |=> !irqFlags[EV_CODE]);
endmodule

bind mgmt_mailbox mbox_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .hostWe  (hostWe),
  .hostRe  (hostRe),
  .hostAddr(hostAddr),
  .slvWe   (slvWe),
  .slvAddr (slvAddr),
  .busy    (busy),
  .irqFlags(irqFlags),
  .hostIrq (hostIrq)
);

// File: tb/mgmt_mailbox_bench.sv
`timescale 1ns/1ps
module mgmt_mailbox_bench;
  localparam int DATA_W = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic hostWe = 0, hostRe = 0, slvWe = 0;
  logic [1:0] hostAddr = 0;
  logic [2:0] slvAddr = 0;
  logic [DATA_W-1:0] hostWdata = 0, slvWdata = 0;
  logic [DATA_W-1:0] hostRdata, slvRdata;
  logic slvIrq, hostIrq;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  mgmt_mailbox #(.DATA_W(DATA_W)) u_mgmt_mailbox (
    .clk(clk), .rstN(rstN),
    .hostWe(hostWe), .hostRe(hostRe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata),
    .slvWe(slvWe), .slvAddr(slvAddr), .slvWdata(slvWdata),
    .slvRdata(slvRdata), .slvIrq(slvIrq), .hostIrq(hostIrq)
  );

  // ---------------- behavioural reference model ----------------
  logic mBusy, mTx, mErr, mPend, nb;
  logic [3:0] mFlags, mEn, ev, clr;
  logic [7:0] mCtrl, mStat, mData;

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mTx = 0; mErr = 0; mPend = 0;
      mFlags = 0; mEn = 0; mCtrl = 0; mStat = 0; mData = 0;
    end else begin
      nb = mBusy;
      if (slvWe && slvAddr == 0) nb = slvWdata[0];
      else if (hostWe && hostAddr == 0 && hostWdata[0]) nb = 1;
      ev = {hostRe && hostAddr == 1,
            hostWe && hostAddr == 2 && !mBusy,
            hostWe && hostAddr == 1 && !mBusy,
            !mBusy && nb};
      clr = (slvWe && slvAddr == 3) ? slvWdata[3:0] : 4'h0;
      if (hostWe && hostAddr == 1 && !mBusy) mCtrl = hostWdata;
      if (hostWe && hostAddr == 2 && !mBusy) mData = hostWdata;
      if (slvWe && slvAddr == 1) mStat = slvWdata;
      if (slvWe && slvAddr == 0) begin mTx = slvWdata[1]; mErr = slvWdata[2]; end
      if (slvWe && slvAddr == 4) mEn = slvWdata[3:0];
      mPend  = (mBusy && !nb) || (mPend && !(hostRe && hostAddr == 0));
      mFlags = ev | (mFlags & ~clr);
      mBusy  = nb;
    end
  end

  function automatic logic [7:0] flagsExp();
    return {4'h0, mPend, mErr, mTx, mBusy};
  endfunction

  function automatic logic [7:0] hostExp(input logic [1:0] a);
    case (a)
      0: return flagsExp();
      1: return mStat;
      2: return mData;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] slvExp(input logic [2:0] a);
    case (a)
      0: return flagsExp();
      1: return mCtrl;
      2: return mData;
      3: return {4'h0, mFlags};
      4: return {4'h0, mEn};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // cycle-by-cycle comparison at each falling edge
  always @(negedge clk) begin
    if (rstN) begin
      chk("model hostRdata", hostRdata, hostExp(hostAddr));
      chk("model slvRdata", slvRdata, slvExp(slvAddr));
      chk("model slvIrq", slvIrq, |(mFlags & mEn));
      chk("model hostIrq", hostIrq, mPend);
    end
  end

  // ---------------- access tasks ----------------
  logic [7:0] hR, sR;
  logic hI, sI;

  task automatic cyc(input logic hw, input logic hr, input logic [1:0] ha,
                     input logic [7:0] hd, input logic sw, input logic [2:0] sa,
                     input logic [7:0] sd);
    @(negedge clk); #1;
    hostWe = hw; hostRe = hr; hostAddr = ha; hostWdata = hd;
    slvWe = sw; slvAddr = sa; slvWdata = sd;
    #1;
    hR = hostRdata; sR = slvRdata; hI = hostIrq; sI = slvIrq;
  endtask

  task automatic idle();              cyc(0, 0, 0, 0, 0, 0, 0); endtask
  task automatic hWr(input logic [1:0] a, input logic [7:0] d); cyc(1, 0, a, d, 0, 0, 0); endtask
  task automatic hRd(input logic [1:0] a); cyc(0, 1, a, 0, 0, 0, 0); endtask
  task automatic sWr(input logic [2:0] a, input logic [7:0] d); cyc(0, 0, 0, 0, 1, a, d); endtask
  task automatic sRd(input logic [2:0] a); cyc(0, 0, 0, 0, 0, a, 0); endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1 reset state
    hRd(0); chk("R1 host flags", hR, 0); chk("R1 hostIrq", hI, 0); chk("R1 slvIrq", sI, 0);
    sRd(3); chk("R1 int status", sR, 0);
    sRd(1); chk("R1 code", sR, 0);

    // slave enables all events, marks ready
    sWr(4, 8'h0F);
    sWr(0, 8'h02);
    hRd(0); chk("R9 ready visible", hR, 8'h02);

    // R4 command code and payload
    hWr(1, 8'h61);
    sRd(3); chk("R4 code event", sR, 8'h02); chk("R7 slvIrq on", sI, 1);
    sRd(1); chk("R4 code value", sR, 8'h61);
    hWr(2, 8'hA5);
    sRd(3); chk("R4 data event", sR, 8'h06);
    sRd(2); chk("R4 data value", sR, 8'hA5);

    // R3 host sets busy; bits 1,2 of host write ignored (R9)
    hWr(0, 8'h07);
    hRd(0); chk("R3/R9 flags after set", hR, 8'h03);
    sRd(3); chk("R3 busy rise event", sR, 8'h07);

    // R2 writes ignored while busy
    hWr(1, 8'h99);
    hWr(2, 8'h11);
    sRd(1); chk("R2 code held", sR, 8'h61);
    sRd(2); chk("R2 data held", sR, 8'hA5);
    sRd(3); chk("R2 no new events", sR, 8'h07);

    // R8 write-one clear
    sWr(3, 8'h07);
    sRd(3); chk("R8 cleared", sR, 0); chk("R7 slvIrq off", sI, 0);

    // R6 slave completes
    sWr(1, 8'h42);
    sWr(0, 8'h00);
    idle(); chk("R6 hostIrq raised", hI, 1);
    idle(); chk("R6 hostIrq held", hI, 1);

    // R5 status read
    hRd(1); chk("R5 status code", hR, 8'h42);
    sRd(3); chk("R5 status event", sR, 8'h08);

    hRd(0); chk("R9 flags with pending", hR, 8'h08);
    idle(); chk("R6 hostIrq cleared by read", hI, 0);

    // R7 enable masking
    sWr(4, 8'h00);
    idle(); chk("R7 masked", sI, 0);
    sWr(4, 8'h08);
    idle(); chk("R7 unmasked", sI, 1);

    // R8 clear and event in same cycle
    cyc(0, 1, 1, 0, 1, 3, 8'h08);
    sRd(3); chk("R8 event beats clear", sR, 8'h08);
    sWr(3, 8'h08);
    sRd(3); chk("R8 clear alone", sR, 0);

    // R10 slave write of flags wins over host set
    cyc(1, 0, 0, 8'h01, 1, 0, 8'h02);
    hRd(0); chk("R10 slave wins", hR, 8'h02);
    sRd(3); chk("R10 no rise event", sR, 0);

    // R6 fall in same cycle as host flag read
    hWr(0, 8'h01);
    cyc(0, 1, 0, 0, 1, 0, 8'h00);
    chk("R6 read shows busy", hR, 8'h03);
    idle(); chk("R6 fall beats read clear", hI, 1);
    hRd(0); chk("R6 pending seen", hR, 8'h08);
    idle(); chk("R6 cleared", hI, 0);

    // R9 abnormal completion: error held across host accesses
    sWr(1, 8'h00);
    sWr(0, 8'h04);
    hRd(0); chk("R9 error set", hR, 8'h04);
    hWr(0, 8'h00);
    hRd(0); chk("R9 error held", hR, 8'h04);
    hRd(1); chk("R9 ready status code", hR, 8'h00);

    idle(); idle();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule